// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory. It watches a clock line and a data line driven by a bus master, recognises start and stop conditions, compares the device-select byte against a fixed code plus a three-bit strap value, and then either takes a two-byte word address and data bytes to store, or streams stored bytes back to the master. Storage is a byte-wide register array inside the block. The data line is open-drain: the block only asserts a pull-low enable, and an external pull-up supplies the high level.

Both lines are brought into the system clock domain through a short synchronizer, and all protocol work runs on that clock. The array size comes from the `ADDR_W` parameter. `ADDR_W = 13` gives the full 8192-byte part with 256 pages of 32 bytes. The default of 11 gives a 2048-byte array that elaborates quickly. A write-protect input locks the top quarter of whichever array size is built.

Top module: `serial_eeprom_slave`

## Requirements
- R1: Data line bits are sampled on the rising edge of SCL. The pull-low enable changes only in the cycle after a synchronized SCL falling edge, start or stop.
- R2: The data line output is a pull-low enable only. It is released (bus reads 1) after reset and after every stop condition.
- R3: A select byte whose upper seven bits equal binary 1010 followed by strap_i[2:0] is acknowledged. The acknowledge pulls the line low during the ninth clock. Any other select byte gets no acknowledge, and the block stays silent until the next start.
- R4: After a select byte with R/W = 0, two word-address bytes follow. The first byte supplies address bits [ADDR_W-1:8] from its low ADDR_W-8 bits, and its other bits are ignored. The second byte supplies bits [7:0]. Both are acknowledged.
- R5: Each data byte of a write is acknowledged and stored. The low five address bits then advance and wrap inside the current 32-byte page, while the upper bits stay fixed.
- R6: With R/W = 1, the block sends bytes starting at the current address. The full address advances after each byte and rolls over from all-ones to zero. Sending continues while the master acknowledges and stops after a master NACK.
- R7: The address counter keeps its value between transfers. A read that is not preceded by an address phase starts at the byte after the last one transferred.
- R8: When wp_i is 1, data bytes aimed at the top quarter (both top address bits set: 0x1800–0x1FFF at 13 bits, 0x600–0x7FF at 11 bits) are acknowledged but leave memory unchanged. Addresses below that range, and any address while wp_i is 0, are written normally.
- R9: A start (SDA falls while SCL is high) or a stop (SDA rises while SCL is high) at any point clears the bit count and the protocol state. A partly received byte is discarded, and after a start the next byte is taken as a select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull-low enable for the data line (1 = drive low) |
| strap_i | input | 3 | Board-strapped device select bits |
| wp_i | input | 1 | Write protect for the upper quarter of the array |

## Verification
The hardest situation to reach from the ports is a condition arriving in the middle of a byte. A stop or a repeated start after only a few data bits must discard the partial byte while keeping the address already loaded. The bench reaches it with a bus-master model that can stop clocking after any number of bits. It then issues the condition with the data line held at the level the partial byte left it at, and reads back through the normal read path to see that nothing was stored and that the counter did not move. Page wrap and address rollover are reached by starting transfers a few bytes before a page end and before the top of the array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DEV    = 3'd1,
    PH_WHI    = 3'd2,
    PH_WLO    = 3'd3,
    PH_WDAT   = 3'd4,
    PH_READ   = 3'd5,
    PH_IGNORE = 3'd6
  } phase_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh_q, sda_sh_q;
  logic scl_p_q, sda_p_q;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_p_q  <= 1'b1;
      sda_p_q  <= 1'b1;
    end else begin
      scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
      sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
      scl_p_q  <= scl_sh_q[STAGES-1];
      sda_p_q  <= sda_sh_q[STAGES-1];
    end
  end

  assign scl_s     = scl_sh_q[STAGES-1];
  assign sda_s     = sda_sh_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p_q;
  assign scl_fall  = ~scl_s & scl_p_q;
  assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

  // R9: a bus condition is never both a start and a stop
  assert_cond_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

  // R1: clock edges and bus conditions never coincide
  assert_edge_vs_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise || scl_fall) |-> !(start_det || stop_det));

endmodule

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_page_i,
  input  logic              inc_seq_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_W-1:0] offs_next;

  assign offs_next = addr_q[PAGE_W-1:0] + 1'b1;

  always_comb begin
    addr_d = addr_q;
    if (load_i) begin
      addr_d = load_val_i;
    end else if (inc_page_i) begin
      addr_d = {addr_q[ADDR_W-1:PAGE_W], offs_next};
    end else if (inc_seq_i) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  // R5: page stepping never disturbs the page number
  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page_i && !load_i) |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));

  // R6: sequential stepping from the top address lands on zero
  assert_seq_rollover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_seq_i && !load_i && !inc_page_i && (&addr_q)) |=> (addr_q == '0));

  // R7: with no command the counter holds
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !inc_page_i && !inc_seq_i) |=> $stable(addr_q));

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              locked;
  logic              wr_en;

  assign locked  = wp_i & (&addr_i[ADDR_W-1:ADDR_W-2]);
  assign wr_en   = we_i & ~locked;
  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  // checker state: remember a blocked write and what the cell held
  logic              blk_q;
  logic [ADDR_W-1:0] blk_addr_q;
  logic [DATA_W-1:0] blk_old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q      <= 1'b0;
      blk_addr_q <= '0;
      blk_old_q  <= '0;
    end else begin
      blk_q      <= we_i & locked;
      blk_addr_q <= addr_i;
      blk_old_q  <= mem_q[addr_i];
    end
  end

  // R8: a write refused by protection leaves the cell as it was
  assert_wp_unchanged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q |-> (mem_q[blk_addr_q] == blk_old_q));

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  localparam int HI_W = ADDR_W - 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int = rst_sync_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  phase_e            phase_q, phase_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [7:0]        tx_q, tx_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              oe_q, oe_d;
  logic              first_q, first_d;
  logic              mack_q, mack_d;

  logic              ctr_load, ctr_page, ctr_seq, mem_we;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        mem_rdata;
  logic              dev_match;

  assign dev_match = (shreg_q[7:1] == {DEV_CODE, strap_i});

  eeprom_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_int),
    .load_i     (ctr_load),
    .load_val_i ({hi_q, shreg_q}),
    .inc_page_i (ctr_page),
    .inc_seq_i  (ctr_seq),
    .addr_o     (addr)
  );

  eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
    .clk     (clk),
    .rst_n   (rst_int),
    .we_i    (mem_we),
    .wp_i    (wp_i),
    .addr_i  (addr),
    .wdata_i (shreg_q),
    .rdata_o (mem_rdata)
  );

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    bit_d    = bit_q;
    shreg_d  = shreg_q;
    tx_d     = tx_q;
    hi_d     = hi_q;
    oe_d     = oe_q;
    first_d  = first_q;
    mack_d   = mack_q;
    ctr_load = 1'b0;
    ctr_page = 1'b0;
    ctr_seq  = 1'b0;
    mem_we   = 1'b0;

    if (stop_det) begin
      phase_d = PH_IDLE;
      bit_d   = 4'd0;
      oe_d    = 1'b0;
    end else if (start_det) begin
      phase_d = PH_DEV;
      bit_d   = 4'd0;
      oe_d    = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise && (bit_q != 4'd9)) begin
        if (bit_q < 4'd8) begin
          shreg_d = {shreg_q[6:0], sda_s};
        end else begin
          mack_d = ~sda_s;
        end
        bit_d = bit_q + 4'd1;
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          // end of a byte: acknowledge slot begins
          case (phase_q)
            PH_DEV: begin
              if (dev_match) begin
                oe_d    = 1'b1;
                first_d = shreg_q[0];
                phase_d = shreg_q[0] ? PH_READ : PH_WHI;
              end else begin
                oe_d    = 1'b0;
                phase_d = PH_IGNORE;
              end
            end
            PH_WHI: begin
              oe_d    = 1'b1;
              hi_d    = shreg_q[HI_W-1:0];
              phase_d = PH_WLO;
            end
            PH_WLO: begin
              oe_d     = 1'b1;
              ctr_load = 1'b1;
              phase_d  = PH_WDAT;
            end
            PH_WDAT: begin
              oe_d     = 1'b1;
              mem_we   = 1'b1;
              ctr_page = 1'b1;
            end
            PH_READ: begin
              oe_d    = 1'b0;
              ctr_seq = 1'b1;
            end
            default: oe_d = 1'b0;
          endcase
        end else if (bit_q == 4'd9) begin
          // end of the acknowledge slot
          bit_d = 4'd0;
          oe_d  = 1'b0;
          if (phase_q == PH_READ) begin
            if (first_q || mack_q) begin
              tx_d    = mem_rdata;
              oe_d    = ~mem_rdata[7];
              first_d = 1'b0;
            end else begin
              phase_d = PH_IGNORE;
            end
          end
        end else if ((phase_q == PH_READ) && (bit_q != 4'd0)) begin
          oe_d = ~tx_q[3'd7 - bit_q[2:0]];
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      phase_q <= PH_IDLE;
      bit_q   <= 4'd0;
      shreg_q <= 8'h00;
      tx_q    <= 8'h00;
      hi_q    <= '0;
      oe_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      tx_q    <= tx_d;
      hi_q    <= hi_d;
      oe_q    <= oe_d;
      first_q <= first_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe = oe_q;

  // R1: the line enable moves only after a falling clock or a bus condition
  assert_oe_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_int)
    !$stable(oe_q) |-> $past(scl_fall || start_det || stop_det));

  // R3: a deselected slave never pulls the line
  assert_silent_ignore_R3: assert property (@(posedge clk) disable iff (!rst_int)
    (phase_q == PH_IGNORE) |-> !oe_q);

  // R9: a bus condition clears the bit count and releases the line
  assert_cond_clears_R9: assert property (@(posedge clk) disable iff (!rst_int)
    (start_det || stop_det) |=> (bit_q == 4'd0) && !oe_q);

  // R2: after a stop the slave is idle with the line released
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_int)
    stop_det |=> (phase_q == PH_IDLE));

  // R5: memory is written only in the write-data phase
  assert_write_phase_R5: assert property (@(posedge clk) disable iff (!rst_int)
    mem_we |-> (phase_q == PH_WDAT) && (bit_q == 4'd8));

endmodule

// File: tb/serial_eeprom_slave_test.sv
`timescale 1ns/1ps
module serial_eeprom_slave_test;

  localparam int AW        = 11;
  localparam int DEPTH     = 1 << AW;
  localparam int PROT_BASE = 3 * (DEPTH / 4);
  localparam int Q         = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       wp = 1'b0;
  wire        sda_oe;
  wire        bus_sda = !(m_low || sda_oe);

  int tests = 0;
  int fails = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  serial_eeprom_slave #(.ADDR_W(AW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (m_scl),
    .sda_i   (bus_sda),
    .sda_oe  (sda_oe),
    .strap_i (strap),
    .wp_i    (wp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(Q); m_low = 1'b0;
    tick(Q); m_scl = 1'b1;
    tick(Q); m_low = 1'b1;
    tick(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); m_low = 1'b1;
    tick(Q); m_scl = 1'b1;
    tick(Q); m_low = 1'b0;
    tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(Q); m_low = !b[i];
      tick(Q); m_scl = 1'b1;
      tick(2*Q); m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    tick(Q); m_low = 1'b0;
    tick(Q); m_scl = 1'b1;
    tick(Q); ack = !bus_sda;
    tick(Q); m_scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_low = 1'b0;
      tick(Q); m_scl = 1'b1;
      tick(Q); b[i] = bus_sda;
      tick(Q); m_scl = 1'b0;
    end
    tick(Q); m_low = mack;
    tick(Q); m_scl = 1'b1;
    tick(2*Q); m_scl = 1'b0;
    tick(Q); m_low = 1'b0;
  endtask

  function automatic logic [7:0] dev_byte(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  // start, select for write, two address bytes (no stop)
  task automatic open_write(input int a, input bit junk);
    bit ack;
    logic [7:0] hi;
    hi = 8'((a >> 8) & ((1 << (AW - 8)) - 1));
    if (junk) hi = hi | 8'hF8;
    bus_start();
    send_byte(dev_byte(1'b0), ack);
    chk(ack, "R3 select ack", ack, 1);
    send_byte(hi, ack);
    chk(ack, "R4 high address ack", ack, 1);
    send_byte(8'(a & 255), ack);
    chk(ack, "R4 low address ack", ack, 1);
  endtask

  task automatic page_write(input int a, input int n, input int base, input bit junk);
    bit ack;
    int ad;
    logic [7:0] d;
    open_write(a, junk);
    for (int i = 0; i < n; i++) begin
      ad = (a & ~31) | ((a + i) & 31);
      d  = 8'((base + i * 37) & 255);
      send_byte(d, ack);
      chk(ack, (wp && ad >= PROT_BASE) ? "R8 protected data ack" : "R5 data ack", ack, 1);
      if (!(wp && ad >= PROT_BASE)) model[ad] = d;
    end
    bus_stop();
    chk(bus_sda == 1'b1, "R2 line released after stop", bus_sda, 1);
  endtask

  task automatic read_check(input int a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    int ad;
    open_write(a, 1'b0);
    bus_start();
    send_byte(dev_byte(1'b1), ack);
    chk(ack, "R3 read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      ad = (a + i) % DEPTH;
      recv_byte(b, i != n - 1);
      chk(b == model[ad], req, b, model[ad]);
    end
    bus_stop();
    chk(bus_sda == 1'b1, "R6 line released after NACK and stop", bus_sda, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;

    tick(5);
    rst_n = 1'b1;
    tick(10);
    chk(sda_oe == 1'b0 && bus_sda == 1'b1, "R2 released after reset", sda_oe, 0);

    // R3: sweep every strap pattern in the select byte, plus a wrong code
    for (int s = 0; s < 8; s++) begin
      bus_start();
      send_byte({4'b1010, 3'(s), 1'b0}, ack);
      chk(ack == (s == 5), "R3 select match sweep", ack, (s == 5));
      bus_stop();
    end
    bus_start();
    send_byte({4'b1011, strap, 1'b0}, ack);
    chk(!ack, "R3 wrong code no ack", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R3 silent after mismatch", ack, 0);
    bus_stop();

    // R4 R5: page write from offset 30 with junk in the high byte, wraps in page
    page_write(32'h0BE, 34, 5, 1'b1);
    read_check(32'h0A0, 32, "R5 page wrap contents R1");

    // R6: sequential read across the top of the array
    page_write(DEPTH - 4, 4, 100, 1'b0);
    page_write(0, 5, 200, 1'b0);
    read_check(DEPTH - 4, 8, "R6 rollover read");

    // R7: current-address read continues at the next byte
    bus_start();
    send_byte(dev_byte(1'b1), ack);
    chk(ack, "R7 select ack", ack, 1);
    recv_byte(b, 1'b0);
    chk(b == model[4], "R7 current address byte", b, model[4]);
    bus_stop();

    // R8: write protect on the top quarter
    page_write(PROT_BASE, 4, 50, 1'b0);
    wp = 1'b1;
    page_write(PROT_BASE - 2, 2, 77, 1'b0);
    page_write(PROT_BASE, 4, 150, 1'b0);
    page_write(DEPTH - 32, 3, 9, 1'b0);
    read_check(PROT_BASE - 2, 6, "R8 protect boundary");
    wp = 1'b0;
    page_write(PROT_BASE + 1, 1, 33, 1'b0);
    read_check(PROT_BASE, 2, "R8 unprotected when wp low");

    // R9: stop in the middle of a data byte
    page_write(32'h101, 1, 85, 1'b0);
    open_write(32'h100, 1'b0);
    send_byte(8'h11, ack);
    chk(ack, "R9 full byte ack", ack, 1);
    model[32'h100] = 8'h11;
    send_bits(8'h22, 4);
    bus_stop();
    chk(bus_sda == 1'b1, "R9 released after mid-byte stop", bus_sda, 1);
    read_check(32'h100, 2, "R9 partial byte discarded");

    // R9: repeated start in the middle of a data byte, then current read
    open_write(32'h101, 1'b0);
    send_bits(8'h3C, 3);
    bus_start();
    send_byte(dev_byte(1'b1), ack);
    chk(ack, "R9 select after repeated start", ack, 1);
    recv_byte(b, 1'b0);
    chk(b == model[32'h101], "R9 counter kept after abort", b, model[32'h101]);
    bus_stop();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule